// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable pipelined synchronous SRAM that never needs an idle cycle between a read and a write. Address, direction, byte-lane selects, chip selects, the cycle-start strobe and the burst-order select are captured on a rising clock edge. The data for that operation is taken from the data-in port, or presented on the data-out port, two enabled clock edges later. A bidirectional data bus is represented as `din`, `dout` and the drive qualifier `dout_en`.

A small controller state machine follows burst progress. It has three states: `ST_IDLE`, `ST_RD_BURST` and `ST_WR_BURST`. It has five transitions:
- *load-read*: cycle start while selected, with `wr_n` high.
- *load-write*: cycle start while selected, with `wr_n` low.
- *deselect*: cycle start while not selected, which leads to `ST_IDLE`.
- *advance*: cycle start high during a burst, which keeps the state and steps the 2-bit beat counter.
- *freeze*: clock enable inactive, which holds every register.

The beat counter gives four addresses from one external address, in linear or interleaved order. An asynchronous output-disable input turns the drivers off at any moment without disturbing the pipeline.

Top module: `psram_top`

## Requirements
- R1: A command captured at enabled edge k is acted on at enabled edge k+2. A write samples `din` at that edge. A read loads `dout` at that edge and raises `dout_en` until the next enabled edge.
- R2: Reads and writes may be issued on every consecutive cycle in any mix. A read issued one or two cycles after a write to the same address returns the newly written data.
- R3: While `clk_en_n` is 1, all other synchronous inputs are ignored. The burst state, the beat counter, the pipeline, the memory, `dout` and `dout_en` all hold their values.
- R4: The device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. When `start_n`=0 and the device is not selected, no operation begins and a running burst ends, so later `start_n`=1 cycles issue nothing. Commands issued earlier still complete.
- R5: `dout_en` is 0 during the cycle after edge k+2 when the command at edge k was a write, a deselect or a no-operation.
- R6: `start_n`=0 while selected loads the address and the direction. `wr_n`=0 selects a write and `wr_n`=1 selects a read. Each later `start_n`=1 cycle issues the next beat in the same direction. The 2-bit beat count wraps after four beats, and the address bits above bit 1 stay constant.
- R7: For beat n, address bits [1:0] are (s+n) mod 4 when `order_il`=0 and s XOR n when `order_il`=1, where s is bits [1:0] of the loaded address. `order_il` is used as it stands at the edge that issues the beat.
- R8: `lane_wr_n[i]`=0 writes bits [9i+8:9i]. Lanes whose select is 1 keep their old contents. Lane selects are sampled with each beat and take effect with that beat's data.
- R9: `out_dis_n`=1 forces `dout_en` to 0 and `dout` to zero at once. Releasing it shows the pending read data again.
- R10: `rst_n`=0 returns the controller to `ST_IDLE`, clears all pending operations and holds `dout_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 freezes the block |
| start_n | input | 1 | 0 loads a new command, 1 advances a running burst |
| addr | input | ADDR_W | Word address |
| wr_n | input | 1 | 0 write, 1 read |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_dis_n | input | 1 | Asynchronous output disable, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |

## Verification
The hardest situation to reach is a clock-enable freeze that falls in the middle of a burst. At that moment, read and write beats are still sitting in the two pipeline stages, and junk commands are present on the inputs. The data must then come out at the right place after the pipeline resumes. A directed sequence stalls a running read burst for several cycles with random addresses and load strobes on the inputs. A seeded random phase then mixes short stalls, deselects, order changes and output disables over thousands of cycles. Every cycle is compared against a cycle model kept in the bench.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } burst_st_e;

    // Low two address bits of burst beat 'step' from origin bits
    function automatic logic [1:0] beat_lo(input logic [1:0] origin,
                                           input logic [1:0] step,
                                           input logic       il);
        logic [1:0] r;
        if (il) r = origin ^ step;
        else    r = origin + step;
        return r;
    endfunction

endpackage

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              start_n,
    input  logic              sel_ok,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lanes_n,
    input  logic              order_il,
    output logic              a_valid,
    output logic              a_wr,
    output logic [ADDR_W-1:0] a_addr,
    output logic [LANES-1:0]  a_lanes_n,
    output burst_st_e         cur_state
);

    burst_st_e         state, n_state;
    logic [ADDR_W-1:0] base, n_base;
    logic [1:0]        cnt, n_cnt;
    logic              iss_v, iss_w;
    logic [ADDR_W-1:0] iss_a;

    // next-state and issue decode
    always_comb begin
        n_state = state;
        n_base  = base;
        n_cnt   = cnt;
        iss_v   = 1'b0;
        iss_w   = 1'b0;
        iss_a   = addr;
        if (!start_n) begin
            if (sel_ok) begin
                // load-read / load-write
                n_state = wr_n ? ST_RD_BURST : ST_WR_BURST;
                n_base  = addr;
                n_cnt   = 2'd0;
                iss_v   = 1'b1;
                iss_w   = !wr_n;
            end else begin
                // deselect
                n_state = ST_IDLE;
            end
        end else begin
            unique case (state)
                ST_IDLE: begin
                    n_state = ST_IDLE;
                end
                ST_RD_BURST, ST_WR_BURST: begin
                    // advance
                    n_cnt = cnt + 2'd1;
                    iss_v = 1'b1;
                    iss_w = (state == ST_WR_BURST);
                    iss_a = {base[ADDR_W-1:2], beat_lo(base[1:0], cnt + 2'd1, order_il)};
                end
                default: n_state = ST_IDLE;
            endcase
        end
    end

    // state register (freeze while hold)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            base  <= '0;
            cnt   <= 2'd0;
        end else if (!hold) begin
            state <= n_state;
            base  <= n_base;
            cnt   <= n_cnt;
        end
    end

    // first pipeline stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid   <= 1'b0;
            a_wr      <= 1'b0;
            a_addr    <= '0;
            a_lanes_n <= '1;
        end else if (!hold) begin
            a_valid   <= iss_v;
            a_wr      <= iss_w;
            a_addr    <= iss_a;
            a_lanes_n <= lanes_n;
        end
    end

    assign cur_state = state;

endmodule

// File: rtl/psram_dly.sv
module psram_dly #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] st [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) st[i] <= '0;
                end else if (!hold) begin
                    for (int i = DEPTH - 1; i > 0; i--) st[i] <= st[i-1];
                    st[0] <= d;
                end
            end
            assign q = st[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lanes_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] bank [WORDS];
            always_ff @(posedge clk) begin
                if (we && !lanes_n[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            assign rdata[g*LANE_W +: LANE_W] = bank[addr];
        end
    endgenerate

endmodule

// File: rtl/psram_top.sv
module psram_top
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    start_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    order_il,
    input  logic                    out_dis_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W  = LANES * LANE_W;
    localparam int LATENCY = 2;
    localparam int MID     = LATENCY - 1;
    localparam int CMD_W   = 2 + ADDR_W + LANES;

    logic              hold, sel_ok;
    logic              a_valid, a_wr;
    logic [ADDR_W-1:0] a_addr;
    logic [LANES-1:0]  a_lanes_n;
    logic              b_valid, b_wr;
    logic [ADDR_W-1:0] b_addr;
    logic [LANES-1:0]  b_lanes_n;
    logic [CMD_W-1:0]  a_pack, b_pack;
    logic [DATA_W-1:0] rdata, dout_q;
    logic              oe_q;
    burst_st_e         cur_state;

    assign hold   = clk_en_n;
    assign sel_ok = !sel1_n && sel2 && !sel3_n;

    psram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .start_n   (start_n),
        .sel_ok    (sel_ok),
        .wr_n      (wr_n),
        .addr      (addr),
        .lanes_n   (lane_wr_n),
        .order_il  (order_il),
        .a_valid   (a_valid),
        .a_wr      (a_wr),
        .a_addr    (a_addr),
        .a_lanes_n (a_lanes_n),
        .cur_state (cur_state)
    );

    assign a_pack = {a_valid, a_wr, a_addr, a_lanes_n};

    psram_dly #(.W(CMD_W), .DEPTH(MID)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .d     (a_pack),
        .q     (b_pack)
    );

    assign {b_valid, b_wr, b_addr, b_lanes_n} = b_pack;

    psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (!hold && b_valid && b_wr),
        .addr    (b_addr),
        .lanes_n (b_lanes_n),
        .wdata   (din),
        .rdata   (rdata)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else if (!hold) begin
            oe_q <= b_valid && !b_wr;
            if (b_valid && !b_wr) dout_q <= rdata;
        end
    end

    assign dout_en = oe_q && !out_dis_n;
    assign dout    = dout_en ? dout_q : '0;

endmodule

// File: rtl/psram_chk.sv
module psram_chk
    import psram_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              start_n,
    input logic              wr_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              out_dis_n,
    input burst_st_e         cur_state,
    input logic              oe_q,
    input logic [DATA_W-1:0] dout_q,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    logic chosen;
    assign chosen = !sel1_n && sel2 && !sel3_n;

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(oe_q) && $stable(dout_q) && $stable(cur_state))); // R3

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !start_n && !chosen) |=> (cur_state == ST_IDLE)); // R4

    AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !start_n && chosen && !wr_n) |=> (cur_state == ST_WR_BURST)); // R6

    AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && start_n) |=> (cur_state == $past(cur_state))); // R6

    AST_NO_DRIVE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !start_n && (!chosen || !wr_n)) ##1 !clk_en_n ##1 !clk_en_n |=> !oe_q); // R5

    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !start_n && chosen && wr_n) ##1 !clk_en_n ##1 !clk_en_n |=> oe_q); // R1

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis_n |-> (!dout_en && (dout == '0))); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !dout_en); // R10

endmodule

bind psram_top psram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .start_n   (start_n),
    .wr_n      (wr_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .out_dis_n (out_dis_n),
    .cur_state (cur_state),
    .oe_q      (oe_q),
    .dout_q    (dout_q),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/test_psram_top.sv
module test_psram_top;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          start_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '0;
    logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic          order_il = 1'b0;
    logic          out_dis_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #5 clk = ~clk;

    psram_top #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_psram_top (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .start_n(start_n),
        .addr(addr), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .order_il(order_il), .out_dis_n(out_dis_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    int total = 0;
    int bad = 0;
    string tag = "R10";

    // cycle model built from the requirements
    int            ms = 0;          // 0 idle, 1 read burst, 2 write burst
    logic [AW-1:0] mbase = '0;
    logic [1:0]    mcnt = '0;
    logic          av = 0, aw = 0, bv = 0, bw = 0;
    logic [AW-1:0] aa = '0, ba = '0;
    logic [NL-1:0] al = '1, bl = '1;
    logic          m_oe = 0;
    logic [DW-1:0] m_q = '0;
    logic [DW-1:0] mm [64];

    function automatic logic [1:0] seq_lo(logic [1:0] s, logic [1:0] n, logic il);
        return il ? (s ^ n) : (s + n);
    endfunction

    task automatic model_edge();
        logic          nv, nw;
        logic [AW-1:0] na;
        if (clk_en_n) return;
        if (bv && !bw) m_q = mm[ba];
        m_oe = bv && !bw;
        if (bv && bw)
            for (int i = 0; i < NL; i++)
                if (!bl[i]) mm[ba][i*LW +: LW] = din[i*LW +: LW];
        bv = av; bw = aw; ba = aa; bl = al;
        nv = 0; nw = 0; na = addr;
        if (!start_n) begin
            if (!sel1_n && sel2 && !sel3_n) begin
                ms = wr_n ? 1 : 2; mbase = addr; mcnt = 0; nv = 1; nw = !wr_n;
            end else ms = 0;
        end else if (ms != 0) begin
            mcnt = mcnt + 2'd1; nv = 1; nw = (ms == 2);
            na = {mbase[AW-1:2], seq_lo(mbase[1:0], mcnt, order_il)};
        end
        av = nv; aw = nw; aa = na; al = lane_wr_n;
    endtask

    task automatic compare(string t);
        logic          e_en;
        logic [DW-1:0] e_d;
        e_en = m_oe && !out_dis_n;
        e_d  = e_en ? m_q : '0;
        total++;
        if (dout_en !== e_en) begin
            bad++;
            $display("FAIL %s dout_en act=%0b exp=%0b t=%0t", t, dout_en, e_en, $time);
        end
        total++;
        if (dout !== e_d) begin
            bad++;
            $display("FAIL %s dout act=%h exp=%h t=%0t", t, dout, e_d, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
        compare(tag);
    endtask

    task automatic cmd(logic st_n, logic w_n, logic [AW-1:0] a);
        start_n = st_n; wr_n = w_n; addr = a;
        din = {$urandom, $urandom};
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cmd(1'b1, 1'b1, '0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) mm[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        tag = "R10";
        compare(tag);                   // R10 during reset
        rst_n = 1'b1;
        idle(3);                        // R10 quiet after reset

        // fill memory with linear write bursts, all lanes
        tag = "R6";
        lane_wr_n = '0;
        for (int b = 0; b < 64; b += 4) begin
            cmd(1'b0, 1'b0, b[AW-1:0]);
            for (int k = 0; k < 3; k++) cmd(1'b1, 1'b1, '0);
        end
        idle(3);

        // R6: linear read burst from an odd start, wrapping past four beats
        order_il = 1'b0;
        cmd(1'b0, 1'b1, 6'd5);
        for (int k = 0; k < 5; k++) cmd(1'b1, 1'b0, 6'd0);
        idle(3);

        // R7: interleaved order, then order change mid-burst
        tag = "R7";
        order_il = 1'b1;
        cmd(1'b0, 1'b1, 6'd10);
        for (int k = 0; k < 3; k++) cmd(1'b1, 1'b1, '0);
        cmd(1'b0, 1'b1, 6'd23);
        cmd(1'b1, 1'b1, '0);
        order_il = 1'b0;
        cmd(1'b1, 1'b1, '0);
        cmd(1'b1, 1'b1, '0);
        idle(3);

        // R8: partial lane writes then read back
        tag = "R8";
        lane_wr_n = 4'b1010;
        cmd(1'b0, 1'b0, 6'd20);
        lane_wr_n = 4'b0111;
        cmd(1'b1, 1'b1, '0);
        lane_wr_n = '0;
        cmd(1'b0, 1'b1, 6'd20);
        cmd(1'b1, 1'b1, '0);
        idle(3);

        // R2: alternating write and read, same and different addresses
        tag = "R2";
        for (int k = 0; k < 6; k++) begin
            cmd(1'b0, 1'b0, 6'(30 + k));
            cmd(1'b0, 1'b1, 6'(30 + k));
        end
        cmd(1'b0, 1'b0, 6'd40);
        cmd(1'b0, 1'b0, 6'd41);
        cmd(1'b0, 1'b1, 6'd40);
        cmd(1'b0, 1'b1, 6'd41);
        idle(3);

        // R3: freeze mid-burst with junk inputs
        tag = "R3";
        cmd(1'b0, 1'b1, 6'd44);
        cmd(1'b1, 1'b1, '0);
        clk_en_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            lane_wr_n = 4'($urandom);
            cmd(1'b0, 1'($urandom), 6'($urandom));
        end
        clk_en_n = 1'b0;
        lane_wr_n = '0;
        for (int k = 0; k < 3; k++) cmd(1'b1, 1'b1, '0);
        idle(3);

        // R4: deselect mid-burst, pending beats drain, advances do nothing
        tag = "R4";
        cmd(1'b0, 1'b1, 6'd48);
        cmd(1'b1, 1'b1, '0);
        sel2 = 1'b0;
        cmd(1'b0, 1'b1, 6'd12);
        sel2 = 1'b1;
        for (int k = 0; k < 4; k++) cmd(1'b1, 1'b1, '0);
        sel3_n = 1'b1;
        cmd(1'b0, 1'b0, 6'd2);
        sel3_n = 1'b0;
        idle(3);

        // R5: read, write, read, deselect mix
        tag = "R5";
        cmd(1'b0, 1'b1, 6'd3);
        cmd(1'b0, 1'b0, 6'd4);
        cmd(1'b0, 1'b1, 6'd4);
        sel1_n = 1'b1;
        cmd(1'b0, 1'b1, 6'd5);
        sel1_n = 1'b0;
        idle(3);

        // R9: asynchronous output disable during a driven read
        tag = "R9";
        cmd(1'b0, 1'b1, 6'd7);
        idle(2);
        out_dis_n = 1'b1;
        #1 compare("R9");
        out_dis_n = 1'b0;
        #1 compare("R9");
        idle(2);

        // R1: seeded random traffic
        tag = "R1";
        for (int k = 0; k < 4000; k++) begin
            clk_en_n  = ($urandom % 8) == 0;
            sel1_n    = ($urandom % 12) == 0;
            sel2      = ($urandom % 12) != 0;
            sel3_n    = ($urandom % 12) == 0;
            order_il  = 1'($urandom);
            out_dis_n = ($urandom % 16) == 0;
            lane_wr_n = 4'($urandom);
            cmd(($urandom % 3) != 0, 1'($urandom), 6'($urandom));
        end
        clk_en_n = 1'b0; out_dis_n = 1'b0;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        idle(4);

        summary();
        $finish;
    end

endmodule